// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from encoder and decoder sub-units into a 32-bit sticky status register. It drives one interrupt request line to the host. Software reaches three 32-bit registers through a simple read/write port. The first is a status register, cleared by writing ones to it. The second is a set register that lets software raise any status bit directly. The third is a mask register, where a bit at 0 lets the matching status bit reach the interrupt line.

Only ten bit positions are wired to hardware events, and their positions are fixed. Encoder events use bits 31 (capture started), 30 (end of stream), 29 (VBI captured), 28 (video input reset) and 27 (encoder DMA done). Decoder events use bits 24 (audio mode changed), 22 (data wanted), 20 (decoder DMA done), 19 (VBI reinserted) and 18 (DMA list fault). Pulses on all other positions are dropped.

After reset, the mask is all ones, so no interrupt is raised. The request line is registered.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0xFFFFFFFF and `irq` is 0.
- R2: A pulse on `event_in` at a wired position sets that status bit at the next clock edge. The wired positions are 31, 30, 29, 28, 27, 24, 22, 20, 19 and 18, giving wired mask 0xF95C0000. The bit stays set after the pulse ends.
- R3: Pulses on `event_in` at unwired positions never set a status bit, so those bits stay 0 unless software sets them.
- R4: A write to offset 0x40 clears every status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R5: A write to offset 0x44 sets every status bit whose data bit is 1, wired or not. Reading offset 0x44 returns 0.
- R6: If a set (hardware event or a write to 0x44) and a clear (a write to 0x40) hit the same bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x48 loads the mask, which reads back unchanged. `irq` is asserted only when some status bit is 1 and its mask bit is 0.
- R8: `irq` follows a change of status or mask one clock edge after the edge that changes those registers.
- R9: A read issued with `rd_en` high presents data on `rd_data` after the next clock edge. `rd_data` holds that value until the next read. Offsets other than 0x40, 0x44 and 0x48 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| event_in | input | DATA_W (32) | Single-cycle event pulses, one per bit |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench drives all 32 event lines at once. A design that lets unwired pulses through would then show bits outside 0xF95C0000. It drives a clear and an event on the same bit in the same cycle, which a clear-priority design would lose. It writes zeros to the clear register, which would wipe status in a design that loads instead of clearing. It checks `irq` both one and two cycles after a mask change and after a clear, so a combinational request line or an extra pipeline stage is caught. It also checks that the mask is all ones after reset and that the set register reads 0, catching an active-high mask and a readable set register.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int EV_W = 32;

  localparam logic [7:0] OFS_STATUS = 8'h40;
  localparam logic [7:0] OFS_SWSET  = 8'h44;
  localparam logic [7:0] OFS_MASK   = 8'h48;

  // encoder event positions
  localparam int EV_ENC_CAP_START = 31;
  localparam int EV_ENC_EOS       = 30;
  localparam int EV_ENC_VBI       = 29;
  localparam int EV_ENC_VIN_RST   = 28;
  localparam int EV_ENC_DMA_DONE  = 27;
  // decoder event positions
  localparam int EV_DEC_AUD_MODE  = 24;
  localparam int EV_DEC_DATA_REQ  = 22;
  localparam int EV_DEC_DMA_DONE  = 20;
  localparam int EV_DEC_VBI_INS   = 19;
  localparam int EV_DEC_LIST_ERR  = 18;

  function automatic logic [EV_W-1:0] wired_events();
    logic [EV_W-1:0] m;
    m = '0;
    m[EV_ENC_CAP_START] = 1'b1;
    m[EV_ENC_EOS]       = 1'b1;
    m[EV_ENC_VBI]       = 1'b1;
    m[EV_ENC_VIN_RST]   = 1'b1;
    m[EV_ENC_DMA_DONE]  = 1'b1;
    m[EV_DEC_AUD_MODE]  = 1'b1;
    m[EV_DEC_DATA_REQ]  = 1'b1;
    m[EV_DEC_DMA_DONE]  = 1'b1;
    m[EV_DEC_VBI_INS]   = 1'b1;
    m[EV_DEC_LIST_ERR]  = 1'b1;
    return m;
  endfunction

  localparam logic [EV_W-1:0] WIRED_MASK = wired_events();
endpackage

// File: rtl/irq_regif.sv
module irq_regif
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = EV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] status_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] sw_set_vec,
  output logic              mask_we,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_SWSET  = ADDR_W'(OFS_SWSET);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);

  logic hit_status, hit_swset, hit_mask;

  always_comb begin
    hit_status = (addr == A_STATUS);
    hit_swset  = (addr == A_SWSET);
    hit_mask   = (addr == A_MASK);
    clr_vec    = (wr_en && hit_status) ? wr_data : '0;
    sw_set_vec = (wr_en && hit_swset)  ? wr_data : '0;
    mask_we    = wr_en && hit_mask;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_status) rd_mux = status_q;
    else if (hit_mask) rd_mux = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_ctl_pkg::*;
#(
  parameter int DATA_W = EV_W,
  parameter logic [DATA_W-1:0] WIRED = DATA_W'(WIRED_MASK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] event_in,
  input  logic [DATA_W-1:0] clr_vec,
  input  logic [DATA_W-1:0] sw_set_vec,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] hw_set;

  for (genvar i = 0; i < DATA_W; i++) begin : g_src
    if (WIRED[i]) begin : g_wired
      assign hw_set[i] = event_in[i];
    end else begin : g_open
      assign hw_set[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_vec) | hw_set | sw_set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end
endmodule

// File: rtl/irq_req.sv
module irq_req #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] status_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic              irq
);
  logic [DATA_W-1:0] live;
  assign live = status_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |live;
  end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = EV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] event_in,
  output logic              irq
);
  logic [DATA_W-1:0] status_q, mask_q, clr_vec, sw_set_vec;
  logic              mask_we;

  irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .status_q(status_q), .mask_q(mask_q),
    .clr_vec(clr_vec), .sw_set_vec(sw_set_vec), .mask_we(mask_we),
    .rd_data(rd_data)
  );

  irq_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .event_in(event_in), .clr_vec(clr_vec),
    .sw_set_vec(sw_set_vec), .mask_we(mask_we), .mask_wdata(wr_data),
    .status_q(status_q), .mask_q(mask_q)
  );

  irq_req #(.DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .status_q(status_q), .mask_q(mask_q), .irq(irq)
  );
endmodule

// File: rtl/irq_stat_ctrl_chk.sv
module irq_stat_ctrl_chk
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = EV_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] event_in,
  input logic              irq,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q
);
  localparam logic [DATA_W-1:0] WM = DATA_W'(WIRED_MASK);
  logic [DATA_W-1:0] clr_v, sw_v, set_v;
  always_comb begin
    clr_v = (wr_en && addr == ADDR_W'(OFS_STATUS)) ? wr_data : '0;
    sw_v  = (wr_en && addr == ADDR_W'(OFS_SWSET))  ? wr_data : '0;
    set_v = (event_in & WM) | sw_v;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '1 && !irq)); // R1
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & ~clr_v)) |=> ((status_q & $past(status_q & ~clr_v)) == $past(status_q & ~clr_v))); // R2
  AST_UNWIRED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|sw_v) |=> ((status_q & ~WM & ~$past(status_q)) == '0)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_v & ~set_v)) |=> ((status_q & $past(clr_v & ~set_v)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((status_q & $past(set_v)) == $past(set_v))); // R6
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_MASK)) |=> (mask_q == $past(wr_data))); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status_q & ~mask_q))); // R8
  AST_IRQ_NO_MISS: assert property (@(posedge clk) disable iff (rst)
    !irq |-> !$past(|(status_q & ~mask_q))); // R8
endmodule

bind irq_stat_ctrl irq_stat_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .event_in(event_in), .irq(irq), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/irq_stat_ctrl_bench.sv
module irq_stat_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0, event_in = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model;

  always #5 clk = ~clk;

  irq_stat_ctrl u_irq_stat_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .event_in(event_in), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(logic [31:0] ev);
    @(negedge clk); event_in = ev;
    @(negedge clk); event_in = '0;
  endtask

  // monitor: pops expected read data after the registered read stage
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("scoreboard underrun", 32'hdead, 32'h0);
        else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h40, 32'h0, "R1 status after reset");
    rd(8'h48, 32'hFFFF_FFFF, "R1 mask after reset");

    // R2 single wired event, sticky
    pulse(32'h8000_0000);
    rd(8'h40, 32'h8000_0000, "R2 encoder start bit");
    rd(8'h40, 32'h8000_0000, "R2 bit stays set");
    // R3 all lines pulsed: only wired positions land
    wr(8'h40, 32'hFFFF_FFFF);
    pulse(32'hFFFF_FFFF);
    model = 32'hF95C_0000;
    rd(8'h40, model, "R3 only wired bits set");
    // R4 partial clear and zero write
    wr(8'h40, 32'h8004_0000);
    model = 32'h795C_0000 & ~32'h0004_0000;
    rd(8'h40, model, "R4 write-one clear");
    wr(8'h40, 32'h0);
    rd(8'h40, model, "R4 zeros keep bits");
    // R5 software set, including unwired positions
    wr(8'h44, 32'h0000_0005);
    model = model | 32'h5;
    rd(8'h40, model, "R5 software set");
    rd(8'h44, 32'h0, "R5 set register reads zero");
    // R6 set beats clear on bit 27
    wr(8'h40, 32'hFFFF_FFFF);
    @(negedge clk); wr_en = 1'b1; addr = 8'h40; wr_data = 32'h0800_0000; event_in = 32'h0800_0000;
    @(negedge clk); wr_en = 1'b0; event_in = '0;
    rd(8'h40, 32'h0800_0000, "R6 event beats clear");
    @(negedge clk); wr_en = 1'b1; addr = 8'h44; wr_data = 32'h0000_0100;
    @(negedge clk); addr = 8'h40; wr_data = 32'h0000_0100;
    @(negedge clk); wr_en = 1'b0;
    rd(8'h40, 32'h0800_0000, "R4 clear after software set");

    // R7 mask read back, irq gating
    wr(8'h48, 32'hF7FF_FFFF);
    check("R8 irq one cycle after mask write", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq with bit unmasked", {31'b0, irq}, 32'h1);
    rd(8'h48, 32'hF7FF_FFFF, "R7 mask read back");
    wr(8'h48, 32'hFFFB_FFFF);
    @(negedge clk);
    check("R7 irq off when pending bit masked", {31'b0, irq}, 32'h0);
    pulse(32'h0004_0000);
    @(negedge clk);
    check("R7 irq from list fault event", {31'b0, irq}, 32'h1);
    wr(8'h40, 32'h0004_0000);
    check("R8 irq still high one cycle after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq drops after clear", {31'b0, irq}, 32'h0);

    // R9 unknown offset and hold
    rd(8'h4C, 32'h0, "R9 unknown offset reads zero");
    repeat (2) @(negedge clk);
    check("R9 rd_data held", rd_data, 32'h0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule